// File: doc/BRIEF.md
# Type-C Floating-Point Min/Max Unit

This unit picks the larger or the smaller of two binary64 operands using a C-style ordering rule rather than the IEEE minNum/maxNum rule. Any NaN on either side makes operand B the result, bit for bit. Equal operands, including a pair of zeros with opposite signs, resolve to A in max mode and to B in min mode. A signaling NaN on either side raises an invalid-operation flag. If the invalid-operation exception is enabled at the same time, the destination write is withheld so that the target keeps its old value.

The ordering is computed on the sign-magnitude encoding. Subnormal operands are used as they are, with no flush to zero. The caller presents the operands with a one-cycle valid strobe. One clock later the unit gives the result, the destination write-enable and the flag, together with a one-cycle done pulse. Instruction decode, the register file, the rest of the status register and trap delivery sit outside this unit.

Top module: `fp_minmax_c`

## Requirements
- R1: When either operand is a NaN (exponent field all ones with a nonzero fraction), the result equals operand B exactly, with the payload unchanged.
- R2: The invalid flag is raised when either operand is a signaling NaN, meaning a NaN whose fraction MSB (bit 51) is 0. A quiet NaN (bit 51 = 1) does not raise it.
- R3: In max mode (`max_sel` = 1) with no NaN present, the result is A unless A < B, in which case it is B. Equal operands give A.
- R4: In min mode (`max_sel` = 0) with no NaN present, the result is A only when A < B, and B otherwise. Equal operands give B.
- R5: When the invalid flag is raised and `inv_en` = 1, `wr_en` stays low during the done cycle.
- R6: +0 and -0 compare as equal, so max(+0,-0) returns A and min(+0,-0) returns B.
- R7: Ordering follows sign-magnitude. Between two negatives, the one with the larger magnitude is smaller. With mixed signs, the negative operand is smaller. Infinities order as the extreme values.
- R8: Subnormal operands are ordered by their raw encoding and are never treated as zero.
- R9: `done`, `res`, `wr_en` and `inv_flag` update on the clock edge that samples `in_valid`. `done` is high for exactly that one cycle. `wr_en` and `inv_flag` are low whenever `done` is low, including after reset.
- R10: When the exception is not enabled, `wr_en` is high on every done cycle, including cycles that return a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| max_sel | input | 1 | 1 selects max, 0 selects min |
| inv_en | input | 1 | Invalid-operation exception enable |
| op_a | input | 64 | Operand A, binary64 |
| op_b | input | 64 | Operand B, binary64 |
| res | output | 64 | Selected operand |
| wr_en | output | 1 | Destination write-enable, valid with done |
| inv_flag | output | 1 | Signaling-NaN invalid flag, valid with done |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that `in_valid` is low while reset is asserted. They also assume that the operands, `max_sel` and `inv_en` are meaningful only in the cycle in which `in_valid` is high. The stimulus meets these assumptions: it keeps `in_valid` low throughout reset and changes every input only on the falling clock edge. The scoreboard predicts each result from a key-based ordering model that is written independently of the comparator. The vectors cover back-to-back operations and idle gaps, quiet and signaling NaNs on each side, both zero signs, subnormals, infinities, and both settings of the exception enable.

// File: rtl/fp_minmax_c.sv
module fp_minmax_c #(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         max_sel,
  input  logic         inv_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res,
  output logic         wr_en,
  output logic         inv_flag,
  output logic         done
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam int MAG_W  = W - 1;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[W-2 -: EXP_W]) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [W-1:0] x);
    return is_nan(x) && !x[FRAC_W-1];
  endfunction

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             sgn_a, sgn_b;
  logic             both_zero, a_lt_b;
  logic             any_nan, any_snan;
  logic [W-1:0]     pick;

  assign sgn_a = op_a[W-1];
  assign sgn_b = op_b[W-1];
  assign mag_a = op_a[MAG_W-1:0];
  assign mag_b = op_b[MAG_W-1:0];
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  always_comb begin
    if (both_zero)          a_lt_b = 1'b0;
    else if (sgn_a != sgn_b) a_lt_b = sgn_a;
    else if (sgn_a)          a_lt_b = mag_a > mag_b;
    else                     a_lt_b = mag_a < mag_b;
  end

  assign any_nan  = is_nan(op_a) || is_nan(op_b);
  assign any_snan = is_snan(op_a) || is_snan(op_b);

  always_comb begin
    if (any_nan)      pick = op_b;
    else if (max_sel) pick = a_lt_b ? op_b : op_a;
    else              pick = a_lt_b ? op_a : op_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res      <= '0;
      wr_en    <= 1'b0;
      inv_flag <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= in_valid;
      wr_en    <= in_valid && !(any_snan && inv_en);
      inv_flag <= in_valid && any_snan;
      if (in_valid) res <= pick;
    end
  end
endmodule

module fp_minmax_c_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         max_sel,
  input logic         inv_en,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] res,
  input logic         wr_en,
  input logic         inv_flag,
  input logic         done
);
  logic a_nan, b_nan;
  assign a_nan = (&op_a[W-2 -: 11]) && (|op_a[W-13:0]);
  assign b_nan = (&op_b[W-2 -: 11]) && (|op_b[W-13:0]);

  a_r9_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr_en && !inv_flag));
  a_r1_nan_gives_b: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_nan || b_nan)) |=> (res == $past(op_b)));
  a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inv_flag && $past(inv_en)) |-> !wr_en);
  a_r10_write_open: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !inv_en) |=> wr_en);
  a_r3_tie_max_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && max_sel && op_a == op_b && !a_nan) |=> (res == $past(op_a)));
endmodule

bind fp_minmax_c fp_minmax_c_chk #(.W(W)) u_chk (.*);

// File: tb/fp_minmax_c_test.sv
module fp_minmax_c_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        max_sel = 1'b0;
  logic        inv_en = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [63:0] res;
  logic        wr_en, inv_flag, done;

  int checks = 0;
  int errors = 0;
  logic [65:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fp_minmax_c uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .max_sel(max_sel),
    .inv_en(inv_en), .op_a(op_a), .op_b(op_b), .res(res),
    .wr_en(wr_en), .inv_flag(inv_flag), .done(done)
  );

  function automatic logic [63:0] key(input logic [63:0] x);
    return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic nanq(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction

  task automatic op(input logic [63:0] a, input logic [63:0] b,
                    input logic mx, input logic ie, input string tag);
    logic lt, sn;
    logic [63:0] r;
    lt = (key(a) < key(b)) && !(a[62:0] == 0 && b[62:0] == 0);
    sn = (nanq(a) && !a[51]) || (nanq(b) && !b[51]);
    if (nanq(a) || nanq(b)) r = b;
    else if (mx)            r = lt ? b : a;
    else                    r = lt ? a : b;
    exp_q.push_back({r, !(sn && ie), sn});
    tag_q.push_back(tag);
    @(negedge clk);
    op_a = a; op_b = b; max_sel = mx; inv_en = ie; in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        logic [65:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected done, res=%h", res);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({res, wr_en, inv_flag} !== e) begin
            errors++;
            $display("FAIL %s: got res=%h wr=%b flag=%b, expected res=%h wr=%b flag=%b",
                     t, res, wr_en, inv_flag, e[65:2], e[1], e[0]);
          end
        end
      end else begin
        checks++;
        if (wr_en || inv_flag) begin
          errors++;
          $display("FAIL R9: idle cycle wr=%b flag=%b, expected 0 0", wr_en, inv_flag);
        end
      end
    end
  end

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QN   = 64'h7FF8_0000_0000_00A5;
  localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0003;
  localparam logic [63:0] NSN  = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || wr_en !== 1'b0 || inv_flag !== 1'b0 || res !== '0) begin
      errors++;
      $display("FAIL R9: reset state done=%b wr=%b flag=%b res=%h, expected 0", done, wr_en, inv_flag, res);
    end
    rst_n = 1'b1;
    op(ONE, TWO, 1, 0, "R3");
    op(TWO, ONE, 1, 0, "R3");
    op(TWO, TWO, 1, 0, "R3");
    op(ONE, TWO, 0, 0, "R4");
    op(TWO, ONE, 0, 0, "R4");
    op(ONE, ONE, 0, 0, "R4");
    idle(2);
    op(PZ, NZ, 1, 0, "R6");
    op(PZ, NZ, 0, 0, "R6");
    op(NZ, PZ, 1, 0, "R6");
    op(NZ, PZ, 0, 0, "R6");
    op(NONE, NTWO, 0, 0, "R7");
    op(NONE, NTWO, 1, 0, "R7");
    op(NONE, TWO, 1, 0, "R7");
    op(ONE, NONE, 0, 0, "R7");
    op(NINF, NTWO, 0, 0, "R7");
    op(PINF, TWO, 1, 0, "R7");
    op(NZ, 64'h0000_0000_0000_0001, 0, 0, "R8");
    op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1, 0, "R8");
    op(64'h8000_0000_0000_0002, 64'h8000_0000_0000_0001, 0, 0, "R8");
    op(64'h000F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, 0, 0, "R8");
    idle(1);
    op(QN, ONE, 1, 0, "R1");
    op(ONE, QN, 0, 1, "R1");
    op(QN, 64'h7FF8_0000_0000_0001, 1, 1, "R1");
    op(SN, TWO, 1, 0, "R2");
    op(ONE, NSN, 0, 0, "R10");
    op(SN, QN, 1, 1, "R5");
    op(TWO, NSN, 0, 1, "R5");
    op(QN, PINF, 0, 1, "R10");
    op(ONE, TWO, 1, 1, "R10");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R9: watchdog expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule